// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is a single-request master for the two-wire PHY management bus. It generates the management clock from the system clock, builds a complete 64-bit frame from one host request, shifts the frame out on the data line, and captures the reply during read frames. One shifter serves both frame formats, the legacy one and the extended one. The formats differ in start code, opcode meaning and the sense of the two address fields. The data line is presented as a separate output value, an output enable and an input, so a pad or a tristate buffer can be placed at chip level.

The host presents a request (format, operation, two 5-bit address fields and a 16-bit payload) while `req_ready` is high. A read returns its 16-bit result on `rd_data` in the cycle in which `done` pulses. Outside a frame the management clock rests low and the data line is released.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 bit times of logic 1, driven by the master (`mdio_oe` high).
- R2: With `req_fmt`=0 (legacy), bits 32..45 of the frame carry start 01, then an opcode of 10 when `req_op[1]`=1 (read) or 01 otherwise (write; address requests `req_op`=00 are also sent as 01), then `req_pa` and then `req_da`. All fields go out MSB first.
- R3: With `req_fmt`=1 (extended), the start code is 00 and the opcode is 00 for `req_op`=00 (address), 01 for `req_op`=01 (write) and 11 for `req_op[1]`=1 (read). `req_pa` carries the port and `req_da` the device, in that order.
- R4: In write and address frames the master drives all 64 bits. Bit positions 46..47 are 1 then 0, and positions 48..63 carry `req_wdata` MSB first.
- R5: In read frames the master releases the line (`mdio_oe` low) from position 46 (the first turnaround bit) through position 63, and never drives while the PHY drives.
- R6: For reads, `mdio_i` is sampled at the MDC rising edges of positions 48..63, MSB first, and appears on `rd_data` in the `done` cycle. Write and address frames leave `rd_data` unchanged, and reset clears it to 0.
- R7: The MDC high phase and low phase each last `cfg_half` system clocks, with 0 treated as 1. The value is taken when the request is accepted, so later changes do not affect the running frame. `mdio_o` changes only while MDC is low.
- R8: After reset and between frames MDC is low, `mdio_oe` is low, `req_ready` is high and `done` is low.
- R9: Each frame produces exactly 64 MDC rising edges. `done` is high for one system clock, exactly one clock after MDC rises for the 64th time.
- R10: A request is accepted only while `req_ready` is high. Raising `req_valid` during a frame has no effect on that frame and starts no extra frame. A request held through the end of a frame is taken once `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | MDC half period in system clocks (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request will be taken |
| req_fmt | input | 1 | 0 legacy format, 1 extended format |
| req_op | input | 2 | 00 address, 01 write, 1x read |
| req_pa | input | 5 | PHY address (legacy) or port address (extended) |
| req_da | input | 5 | Register address (legacy) or device address (extended) |
| req_wdata | input | 16 | Write data or register address payload |
| rd_data | output | 16 | Data returned by the last read frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
Two events can fall in the same system cycle. The first is the end-of-frame `done` pulse; the second is the return of `req_ready`, together with the acceptance of a waiting request. With a one-clock half period the final MDC fall coincides with `done`. The bench provokes both cases by running frames at half periods of 1 and 2 and by holding a second request asserted across the end of a frame. It judges the result from the captured bus: the first frame must be complete and correct, the held request must produce exactly one following frame with its own contents, and a request raised mid-frame must produce none.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // frame field widths
  localparam int PRE_W   = 32;
  localparam int ST_W    = 2;
  localparam int OPC_W   = 2;
  localparam int ADR_W   = 5;
  localparam int TA_W    = 2;
  localparam int DAT_W   = 16;

  // derived frame geometry
  localparam int HDR_W   = PRE_W + ST_W + OPC_W + 2 * ADR_W;
  localparam int FRAME_W = HDR_W + TA_W + DAT_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  // host operation codes
  localparam logic [1:0] REQ_ADDR  = 2'b00;
  localparam logic [1:0] REQ_WRITE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } mst_state_t;

  typedef struct packed {
    logic             ext;
    logic [1:0]       op;
    logic [ADR_W-1:0] pa;
    logic [ADR_W-1:0] da;
    logic [DAT_W-1:0] payload;
  } mdio_req_t;

endpackage

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
  import mdio_pkg::*;
(
  input  mdio_req_t          req,
  output logic [FRAME_W-1:0] bits,
  output logic [FRAME_W-1:0] drv,
  output logic               is_rd
);

  logic [ST_W-1:0]  st_code;
  logic [OPC_W-1:0] op_code;
  logic [TA_W-1:0]  ta_code;
  logic [DAT_W-1:0] data_fld;

  always_comb begin
    is_rd = req.op[1];

    // start code and opcode depend on the format
    if (req.ext) begin
      st_code = 2'b00;
      if (is_rd)                   op_code = 2'b11;
      else if (req.op == REQ_WRITE) op_code = 2'b01;
      else                          op_code = 2'b00;
    end else begin
      st_code = 2'b01;
      op_code = is_rd ? 2'b10 : 2'b01;
    end

    // master drives 1,0 for writes; on reads the bits are released
    ta_code  = is_rd ? 2'b00 : 2'b10;
    data_fld = is_rd ? {DAT_W{1'b0}} : req.payload;

    bits = {{PRE_W{1'b1}}, st_code, op_code, req.pa, req.da, ta_code, data_fld};
    drv  = {{HDR_W{1'b1}}, {(TA_W + DAT_W){~is_rd}}};
  end

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_in,
  output logic             mdc,
  output logic             rise_now,
  output logic             fall_now
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == half_q - ONE);
  assign rise_now = tick && !mdc;
  assign fall_now = tick &&  mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= ONE;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= (half_in == '0) ? ONE : half_in;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      mdc    <= ~mdc;
    end else begin
      cnt    <= cnt + ONE;
    end
  end

  // the programmed phase length can never be zero once a frame runs
  assert_half_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> (half_q != '0));

endmodule

// File: rtl/mdio_shift_ctl.sv
module mdio_shift_ctl
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FRAME_W-1:0] frm_bits,
  input  logic [FRAME_W-1:0] frm_drv,
  input  logic               frm_rd,
  input  logic               rise_now,
  input  logic               fall_now,
  input  logic               mdio_i,
  output logic               start,
  output logic               run,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DAT_W-1:0]   rd_data,
  output logic               done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_W - DAT_W);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(HDR_W);

  mst_state_t         state;
  logic [FRAME_W-1:0] sh_bits;
  logic [FRAME_W-1:0] sh_drv;
  logic [IDX_W-1:0]   bit_idx;
  logic               rd_q;
  logic [DAT_W-1:0]   rd_sh;
  logic               last_q;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign run       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh_bits <= '0;
      sh_drv  <= '0;
      bit_idx <= '0;
      rd_q    <= 1'b0;
      rd_sh   <= '0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      last_q <= 1'b0;
      done   <= last_q;
      if (last_q) begin
        mdio_oe <= 1'b0;
        if (rd_q) rd_data <= rd_sh;
      end

      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= ST_RUN;
            mdio_o  <= frm_bits[FRAME_W-1];
            mdio_oe <= frm_drv[FRAME_W-1];
            sh_bits <= {frm_bits[FRAME_W-2:0], 1'b0};
            sh_drv  <= {frm_drv[FRAME_W-2:0], 1'b0};
            bit_idx <= '0;
            rd_q    <= frm_rd;
            rd_sh   <= '0;
          end
        end
        ST_RUN: begin
          if (rise_now) begin
            if (rd_q && (bit_idx >= DATA_IDX))
              rd_sh <= {rd_sh[DAT_W-2:0], mdio_i};
            if (bit_idx == LAST_IDX) begin
              last_q <= 1'b1;
              state  <= ST_TAIL;
            end
          end else if (fall_now) begin
            mdio_o  <= sh_bits[FRAME_W-1];
            mdio_oe <= sh_drv[FRAME_W-1];
            sh_bits <= {sh_bits[FRAME_W-2:0], 1'b0};
            sh_drv  <= {sh_drv[FRAME_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_TAIL: begin
          if (fall_now) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read frames leave the line to the PHY from the first turnaround bit on
  assert_read_released_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && rd_q && bit_idx >= REL_IDX) |-> !mdio_oe);

  // the bit position moves only on an MDC falling edge
  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !rise_now && !fall_now) |=> $stable(bit_idx));

  // done follows the last rising edge by one system clock
  assert_done_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rise_now, 2));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_fmt,
  input  logic [1:0]       req_op,
  input  logic [4:0]       req_pa,
  input  logic [4:0]       req_da,
  input  logic [15:0]      req_wdata,
  output logic [15:0]      rd_data,
  output logic             done,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  mdio_req_t          req;
  logic [FRAME_W-1:0] frm_bits;
  logic [FRAME_W-1:0] frm_drv;
  logic               frm_rd;
  logic               start;
  logic               run;
  logic               rise_now;
  logic               fall_now;

  assign req = '{ext: req_fmt, op: req_op, pa: req_pa, da: req_da, payload: req_wdata};

  mdio_frame_fmt u_fmt (
    .req   (req),
    .bits  (frm_bits),
    .drv   (frm_drv),
    .is_rd (frm_rd)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (run),
    .half_in  (cfg_half),
    .mdc      (mdc),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  mdio_shift_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .frm_bits  (frm_bits),
    .frm_drv   (frm_drv),
    .frm_rd    (frm_rd),
    .rise_now  (rise_now),
    .fall_now  (fall_now),
    .mdio_i    (mdio_i),
    .start     (start),
    .run       (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data),
    .done      (done)
  );

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mdc && !mdio_oe));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_mdo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_half = 8'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_fmt = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_pa = '0;
  logic [4:0]  req_da = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rd_data;
  logic        done;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  assign mdio_i = phy_drv ? phy_bit : 1'b1;

  always #5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_fmt(req_fmt),
    .req_op(req_op), .req_pa(req_pa), .req_da(req_da), .req_wdata(req_wdata),
    .rd_data(rd_data), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // ---------------- bus monitor and PHY model ----------------
  int cyc = 0;
  logic        nxt_rd = 1'b0;
  logic [15:0] nxt_phy = '0;
  int          nxt_half = 1;
  logic        f_rd = 1'b0;
  logic [15:0] f_phy = '0;
  int          f_half = 1;
  int          rise_cnt = 0;
  int          rise_cyc = 0, fall_cyc = 0;
  bit          fall_seen = 0;
  logic [63:0] cap_bus = '0, cap_oe = '0;
  int          hierr = 0, loerr = 0, mdoerr = 0, cont = 0;
  logic        prev_mdc = 1'b0, prev_bus = 1'b1, prev_oe = 1'b0, prev_mdo = 1'b1, prev_ready = 1'b1;
  int          done_cnt = 0;
  logic [63:0] sn_bus, sn_oe;
  int          sn_rises, sn_gap, sn_hierr, sn_loerr, sn_mdoerr, sn_cont;
  logic [15:0] sn_rd;

  always @(negedge clk) begin
    cyc++;
    if (prev_ready && !req_ready) begin
      f_rd = nxt_rd; f_phy = nxt_phy; f_half = nxt_half;
      rise_cnt = 0; fall_seen = 0; cap_bus = '0; cap_oe = '0;
      hierr = 0; loerr = 0; mdoerr = 0; cont = 0;
    end
    if (mdc && !prev_mdc) begin
      rise_cnt++;
      cap_bus = {cap_bus[62:0], prev_bus};
      cap_oe  = {cap_oe[62:0], prev_oe};
      if (fall_seen && (cyc - fall_cyc) != f_half) loerr++;
      rise_cyc = cyc;
      if (rise_cnt == 64) phy_drv = 1'b0;
    end
    if (!mdc && prev_mdc) begin
      fall_seen = 1;
      if ((cyc - rise_cyc) != f_half) hierr++;
      fall_cyc = cyc;
      if (f_rd && rise_cnt >= 47 && rise_cnt <= 63) begin
        phy_drv = 1'b1;
        phy_bit = (rise_cnt == 47) ? 1'b0 : f_phy[63 - rise_cnt];
      end
    end
    if (mdc && prev_mdc && mdio_o != prev_mdo) mdoerr++;
    if (mdio_oe && phy_drv) cont++;
    if (done) begin
      sn_bus = cap_bus; sn_oe = cap_oe; sn_rises = rise_cnt; sn_gap = cyc - rise_cyc;
      sn_hierr = hierr; sn_loerr = loerr; sn_mdoerr = mdoerr; sn_cont = cont; sn_rd = rd_data;
      done_cnt++;
    end
    prev_mdc = mdc;
    prev_bus = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);
    prev_oe  = mdio_oe;
    prev_mdo = mdio_o;
    prev_ready = req_ready;
  end

  // ---------------- expected values from the requirements ----------------
  function automatic logic [63:0] exp_frame(input bit fmt, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] da, input logic [15:0] wd, input logic [15:0] phy);
    logic [1:0] st, oc;
    bit rd;
    rd = op[1];
    st = fmt ? 2'b00 : 2'b01;
    if (fmt) oc = rd ? 2'b11 : ((op == 2'b01) ? 2'b01 : 2'b00);
    else     oc = rd ? 2'b10 : 2'b01;
    // on reads the released first turnaround bit reads back as 1 via the pull-up
    return {32'hFFFF_FFFF, st, oc, pa, da, 2'b10, (rd ? phy : wd)};
  endfunction

  task automatic check_snap(input string tag, input bit fmt, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] da, input logic [15:0] wd, input logic [15:0] phy);
    logic [63:0] ef, eo;
    bit rd;
    rd = op[1];
    ef = exp_frame(fmt, op, pa, da, wd, phy);
    eo = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    chk(sn_bus[63:32] == 32'hFFFF_FFFF && sn_oe[63:32] == 32'hFFFF_FFFF, "R1 preamble", sn_bus, ef);
    chk(sn_bus == ef, tag, sn_bus, ef);
    if (rd) begin
      chk(sn_oe == eo, "R5 release window", sn_oe, eo);
      chk(sn_cont == 0, "R5 no contention", 64'(sn_cont), 64'd0);
      chk(sn_rd == phy, "R6 read data", 64'(sn_rd), 64'(phy));
    end else begin
      chk(sn_oe == eo, "R4 drive all bits", sn_oe, eo);
      chk(sn_bus[17:0] == {2'b10, wd}, "R4 ta and data", 64'(sn_bus[17:0]), 64'({2'b10, wd}));
    end
    chk(sn_rises == 64 && sn_gap == 1, "R9 rises and done timing",
        64'(sn_rises) << 8 | 64'(sn_gap), 64'(64) << 8 | 64'd1);
    chk(sn_hierr == 0 && sn_loerr == 0, "R7 phase length", 64'(sn_hierr + sn_loerr), 64'd0);
    chk(sn_mdoerr == 0, "R7 data stable while mdc high", 64'(sn_mdoerr), 64'd0);
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    chk(!mdc && !mdio_oe && !done, "R8 idle quiet", {mdc, mdio_oe, done}, 3'b000);
  endtask

  // mode 0 plain, 1 change cfg_half mid-frame, 2 pulse req_valid mid-frame
  task automatic do_frame(input string tag, input bit fmt, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] da, input logic [15:0] wd,
      input logic [15:0] phy, input logic [7:0] half, input int mode);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nxt_rd = op[1]; nxt_phy = phy; nxt_half = (half == 0) ? 1 : int'(half);
    cfg_half = half; req_fmt = fmt; req_op = op; req_pa = pa; req_da = da; req_wdata = wd;
    n = done_cnt;
    req_valid = 1'b1;
    @(negedge clk);
    while (req_ready) @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == n) begin
      @(negedge clk);
      if (mode == 1 && rise_cnt == 10) cfg_half = 8'd1;
      if (mode == 2) begin
        if (rise_cnt >= 10 && rise_cnt < 14) begin
          req_valid = 1'b1; req_fmt = ~fmt; req_op = 2'b11; req_pa = ~pa; req_da = ~da; req_wdata = ~wd;
        end else req_valid = 1'b0;
      end
    end
    check_snap(tag, fmt, op, pa, da, wd, phy);
    wait_idle();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready && !mdc && !mdio_oe && !done, "R8 reset state",
        {req_ready, mdc, mdio_oe, done}, 4'b1000);
    chk(rd_data == 16'h0, "R6 reset rd_data", 64'(rd_data), 64'd0);
  endtask

  task automatic t_legacy_write();
    do_frame("R2 legacy write frame", 1'b0, 2'b01, 5'h13, 5'h0A, 16'hBEEF, 16'h0, 8'd2, 0);
  endtask

  task automatic t_legacy_read();
    do_frame("R2 legacy read frame", 1'b0, 2'b10, 5'h01, 5'h1F, 16'h0, 16'hA5C3, 8'd3, 0);
  endtask

  task automatic t_legacy_addr_keeps_rd();
    do_frame("R2 legacy address op sent as write", 1'b0, 2'b00, 5'h1E, 5'h02, 16'h1234, 16'h0, 8'd1, 0);
    chk(rd_data == 16'hA5C3, "R6 rd_data kept after write", 64'(rd_data), 64'hA5C3);
  endtask

  task automatic t_ext_addr();
    do_frame("R3 extended address frame", 1'b1, 2'b00, 5'h05, 5'h03, 16'hC0DE, 16'h0, 8'd0, 0);
  endtask

  task automatic t_ext_write();
    do_frame("R3 extended write frame", 1'b1, 2'b01, 5'h1A, 5'h07, 16'h0F0F, 16'h0, 8'd2, 0);
  endtask

  task automatic t_ext_read();
    do_frame("R3 extended read frame", 1'b1, 2'b11, 5'h00, 5'h1E, 16'h0, 16'h8001, 8'd1, 0);
  endtask

  task automatic t_half_latch();
    do_frame("R7 half period latched", 1'b0, 2'b01, 5'h0C, 5'h11, 16'h5AA5, 16'h0, 8'd3, 1);
    cfg_half = 8'd2;
  endtask

  task automatic t_busy_ignore();
    int n;
    do_frame("R10 frame unaffected by busy request", 1'b1, 2'b01, 5'h09, 5'h04, 16'h3C3C, 16'h0, 8'd2, 2);
    n = done_cnt;
    repeat (40) @(negedge clk);
    chk(done_cnt == n && rise_cnt == 64 && req_ready, "R10 no extra frame",
        64'(done_cnt - n), 64'd0);
  endtask

  task automatic t_back_to_back();
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nxt_rd = 1'b0; nxt_phy = 16'h0; nxt_half = 2;
    cfg_half = 8'd2; req_fmt = 1'b0; req_op = 2'b01; req_pa = 5'h15; req_da = 5'h0B; req_wdata = 16'h6D6D;
    n = done_cnt;
    req_valid = 1'b1;
    @(negedge clk);
    while (req_ready) @(negedge clk);
    @(negedge clk);
    // second request waits with valid held high
    nxt_rd = 1'b1; nxt_phy = 16'h7E81; nxt_half = 2;
    req_fmt = 1'b1; req_op = 2'b11; req_pa = 5'h02; req_da = 5'h01; req_wdata = 16'h0;
    while (done_cnt == n) @(negedge clk);
    check_snap("R10 first of held pair", 1'b0, 2'b01, 5'h15, 5'h0B, 16'h6D6D, 16'h0);
    while (!req_ready) @(negedge clk);
    while (req_ready) @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == n + 1) @(negedge clk);
    check_snap("R10 held request taken", 1'b1, 2'b11, 5'h02, 5'h01, 16'h0, 16'h7E81);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(done_cnt == n + 2, "R10 exactly two frames", 64'(done_cnt - n), 64'd2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_legacy_write();
    t_legacy_read();
    t_legacy_addr_keeps_rd();
    t_ext_addr();
    t_ext_write();
    t_ext_read();
    t_half_latch();
    t_busy_ignore();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule